// File: doc/BRIEF.md
# Absolute Encoder Position Read Master

This block reads an absolute position from a rotary or linear encoder over a two-wire synchronous serial link. The master owns the clock line and the encoder answers on a return data line. Between reads the clock line rests high. A read can begin only when the encoder shows it is ready by holding the return line high. The master then drives a burst of clock periods. Each half period lasts a fixed number of system clocks.

The encoder pulls the return line low to acknowledge. It computes the position during this phase, which has no fixed length. It then sends a start bit, a fixed zero bit, the position MSB first, an error flag, a warning flag and an inverted 6-bit CRC. The master checks the CRC. It presents the position, the two flags turned active high and a CRC-valid flag, together with a one-cycle done pulse. If no start bit comes within a set number of clock periods, the read is abandoned and a timeout flag is raised.

The return line passes through a synchronizer inside the block. The round trip of the line, plus SYNC_STAGES + 1 system clocks, must stay below one full serial clock period (2 × HALF_DIV system clocks). HALF_DIV must be at least 2.

Top module: `enc_rd_master`

## Requirements
- R1: After reset, and whenever no read is in progress, sclk_o is 1 and busy_o is 0. Reset clears pos_o, err_o, warn_o, crc_ok_o, done_o and timeout_o to 0.
- R2: A pulse on req_i starts a read only when busy_o is 0 and the synchronized return line is 1. A request made while the line is 0, or while a read is in progress, has no effect.
- R3: The first falling edge of sclk_o comes HALF_DIV system clocks after the clock edge that accepts the request. Every later half period of sclk_o lasts exactly HALF_DIV system clocks.
- R4: The return line is sampled on each rising edge of sclk_o and captures the bit the encoder launched on the previous rising edge. Samples at the first two rising edges are discarded. From the third rising edge on, the master waits for a sample of 1, which is the start bit. The acknowledge phase may last from 1 to ACK_LIMIT-1 periods.
- R5: The bit after the start bit is the zero bit. The next POS_W bits are the position, MSB first, and they appear on pos_o.
- R6: After the position come an error bit and then a warning bit, both active low on the line. err_o is the inverse of the error bit and warn_o is the inverse of the warning bit.
- R7: The CRC register starts at 0 and runs x^6 + x + 1 (feedback taps 6'b000011). It shifts MSB first over the position, error and warning bits only. The encoder sends the 6-bit CRC inverted. crc_ok_o is 1 only when the inverted received CRC equals the computed value and the zero bit was 0.
- R8: If ACK_LIMIT samples in a row from the third rising edge are all 0, the read is abandoned. This happens on the ACK_LIMIT-th of those rising edges, which is rising edge 2+ACK_LIMIT in total. sclk_o then stays high, busy_o falls and timeout_o rises, while done_o does not pulse and pos_o, err_o, warn_o and crc_ok_o keep their values. timeout_o clears when the next request is accepted.
- R9: The rising edge that samples the last CRC bit is the last one; no further edges follow. done_o pulses for exactly one system clock, in the cycle the new outputs appear. The outputs then hold until the next completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request |
| sdi_i | input | 1 | Return data line from the encoder (asynchronous) |
| sclk_o | output | 1 | Serial clock to the encoder, high when idle |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse when a read completes |
| timeout_o | output | 1 | Acknowledge timeout fault, held until the next accepted request |
| pos_o | output | POS_W | Captured position |
| err_o | output | 1 | Encoder reports untrustworthy position (active high) |
| warn_o | output | 1 | Encoder reports cleaning needed (active high) |
| crc_ok_o | output | 1 | CRC matched and zero bit was 0 |

## Verification
The checker watches several properties on every cycle. The serial clock must rest high while idle, and no half period may be shorter than HALF_DIV. Requests made while the line is low must be refused. The done pulse must last one cycle, the outputs must hold between completions, and a timeout must leave the link idle and clear on the next accepted request. Only the bench scenarios can show the rest: the actual field order and bit decode, the inverted CRC and zero-bit checks, the exact rising-edge count at which the acknowledge timeout fires, and the success of the longest allowed acknowledge. The bench drives a behavioural encoder that reacts to the serial clock edges.

// File: rtl/enc_rd_pkg.sv
`timescale 1ns/1ps
package enc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACK,
    ST_ZERO,
    ST_DATA,
    ST_CRC,
    ST_FIN
  } rd_state_e;

  localparam int          CRC_W    = 6;
  localparam logic [5:0]  CRC_POLY = 6'b000011;

  // One serial step of the 6-bit check polynomial, message bit MSB first.
  function automatic logic [CRC_W-1:0] crc6_step(logic [CRC_W-1:0] cur, logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/enc_rd_sync.sv
`timescale 1ns/1ps
module enc_rd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/enc_rd_clkgen.sv
`timescale 1ns/1ps
module enc_rd_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic rise_o,
  output logic sclk_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign rise_o = tick && !sclk_q;
  assign sclk_o = sclk_q;

endmodule

// File: rtl/enc_rd_crc6.sv
`timescale 1ns/1ps
module enc_rd_crc6
  import enc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = crc6_step(crc_q, bit_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/enc_rd_master.sv
`timescale 1ns/1ps
module enc_rd_master
  import enc_rd_pkg::*;
#(
  parameter int POS_W       = 26,
  parameter int HALF_DIV    = 4,
  parameter int ACK_LIMIT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             sdi_i,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [POS_W-1:0] pos_o,
  output logic             err_o,
  output logic             warn_o,
  output logic             crc_ok_o
);

  localparam int DATA_W = POS_W + 2;
  localparam int BCW    = $clog2(DATA_W + 1);
  localparam int ACW    = $clog2(ACK_LIMIT + 1);

  rd_state_e         state_q, state_d;
  logic [BCW-1:0]    bit_cnt_q, bit_cnt_d;
  logic [ACW-1:0]    ack_cnt_q, ack_cnt_d;
  logic [DATA_W-1:0] data_sr_q, data_sr_d;
  logic [CRC_W-1:0]  crc_rx_q, crc_rx_d;
  logic [CRC_W-1:0]  crc_calc;
  logic              zero_bad_q, zero_bad_d;

  logic              sdi_s;
  logic              rise;
  logic              run;
  logic              crc_clr, crc_en, cap, to_set, to_clr;

  logic [POS_W-1:0]  pos_q;
  logic              err_q, warn_q, ok_q, done_q, to_q;

  // Return line into the system clock domain; reset value reads as not ready.
  enc_rd_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (sdi_i),
    .q_o  (sdi_s)
  );

  assign run = (state_q != ST_IDLE) && (state_q != ST_FIN);

  enc_rd_clkgen #(
    .HALF_DIV(HALF_DIV)
  ) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run),
    .rise_o(rise),
    .sclk_o(sclk_o)
  );

  enc_rd_crc6 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(crc_clr),
    .en_i (crc_en),
    .bit_i(sdi_s),
    .crc_o(crc_calc)
  );

  // Next-state logic: every sample is taken on a rising tick, using the
  // bit the encoder launched one full period earlier.
  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    ack_cnt_d  = ack_cnt_q;
    data_sr_d  = data_sr_q;
    crc_rx_d   = crc_rx_q;
    zero_bad_d = zero_bad_q;
    crc_clr    = 1'b0;
    crc_en     = 1'b0;
    cap        = 1'b0;
    to_set     = 1'b0;
    to_clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && sdi_s) begin
          state_d    = ST_LEAD;
          bit_cnt_d  = '0;
          zero_bad_d = 1'b0;
          crc_clr    = 1'b1;
          to_clr     = 1'b1;
        end
      end
      ST_LEAD: begin
        if (rise) begin
          if (bit_cnt_q == BCW'(1)) begin
            state_d   = ST_ACK;
            ack_cnt_d = '0;
          end else begin
            bit_cnt_d = bit_cnt_q + 1'b1;
          end
        end
      end
      ST_ACK: begin
        if (rise) begin
          if (sdi_s) begin
            state_d = ST_ZERO;
          end else if (ack_cnt_q == ACW'(ACK_LIMIT - 1)) begin
            state_d = ST_IDLE;
            to_set  = 1'b1;
          end else begin
            ack_cnt_d = ack_cnt_q + 1'b1;
          end
        end
      end
      ST_ZERO: begin
        if (rise) begin
          zero_bad_d = sdi_s;
          bit_cnt_d  = '0;
          state_d    = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rise) begin
          data_sr_d = {data_sr_q[DATA_W-2:0], sdi_s};
          crc_en    = 1'b1;
          if (bit_cnt_q == BCW'(DATA_W - 1)) begin
            bit_cnt_d = '0;
            state_d   = ST_CRC;
          end else begin
            bit_cnt_d = bit_cnt_q + 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (rise) begin
          crc_rx_d = {crc_rx_q[CRC_W-2:0], sdi_s};
          if (bit_cnt_q == BCW'(CRC_W - 1)) begin
            state_d = ST_FIN;
          end else begin
            bit_cnt_d = bit_cnt_q + 1'b1;
          end
        end
      end
      ST_FIN: begin
        cap     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      ack_cnt_q  <= '0;
      data_sr_q  <= '0;
      crc_rx_q   <= '0;
      zero_bad_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      ack_cnt_q  <= ack_cnt_d;
      data_sr_q  <= data_sr_d;
      crc_rx_q   <= crc_rx_d;
      zero_bad_q <= zero_bad_d;
    end
  end

  // Result registers, loaded only on completion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (cap) begin
      pos_q  <= data_sr_q[DATA_W-1:2];
      err_q  <= ~data_sr_q[1];
      warn_q <= ~data_sr_q[0];
      ok_q   <= ((~crc_rx_q) == crc_calc) && !zero_bad_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      done_q <= cap;
      if (to_set) begin
        to_q <= 1'b1;
      end else if (to_clr) begin
        to_q <= 1'b0;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign pos_o     = pos_q;
  assign err_o     = err_q;
  assign warn_o    = warn_q;
  assign crc_ok_o  = ok_q;

endmodule

// File: rtl/enc_rd_checker.sv
`timescale 1ns/1ps
module enc_rd_checker #(
  parameter int POS_W    = 26,
  parameter int HALF_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             ready_i,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             timeout_o,
  input logic [POS_W-1:0] pos_o,
  input logic             err_o,
  input logic             warn_o,
  input logic             crc_ok_o
);

  logic        sclk_prev;
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      run_len   <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (sclk_o != sclk_prev) begin
        run_len <= '0;
      end else if (run_len != 16'hFFFF) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);  // R1

  AST_NOT_READY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && !ready_i) |=> !busy_o);  // R2

  AST_READY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && ready_i) |=> busy_o);  // R2

  AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != sclk_prev) |-> (run_len >= 16'(HALF_DIV - 1)));  // R3

  AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (!done_o && !busy_o && sclk_o));  // R8

  AST_TIMEOUT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && ready_i) |=> !timeout_o);  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(pos_o) && $stable(err_o) && $stable(warn_o) && $stable(crc_ok_o)));  // R9

endmodule

bind enc_rd_master enc_rd_checker #(
  .POS_W   (POS_W),
  .HALF_DIV(HALF_DIV)
) u_enc_rd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .ready_i  (sdi_s),
  .sclk_o   (sclk_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .pos_o    (pos_o),
  .err_o    (err_o),
  .warn_o   (warn_o),
  .crc_ok_o (crc_ok_o)
);

// File: tb/test_enc_rd_master.sv
`timescale 1ns/1ps
module test_enc_rd_master;

  localparam int CLK_PERIOD = 10;
  localparam int POS_W      = 26;
  localparam int HALF_DIV   = 4;
  localparam int ACK_LIMIT  = 32;

  logic             clk;
  logic             rst_n;
  logic             req;
  logic             sdi;
  logic             sclk_o;
  logic             busy_o;
  logic             done_o;
  logic             timeout_o;
  logic [POS_W-1:0] pos_o;
  logic             err_o;
  logic             warn_o;
  logic             crc_ok_o;

  typedef struct {
    bit               tmo;
    logic [POS_W-1:0] pos;
    logic             err;
    logic             warn;
    logic             ok;
  } exp_t;

  exp_t             exp_q[$];
  int               checks;
  int               fails;
  int               sclk_rises;
  bit               finished;
  logic             to_prev;
  logic [POS_W-1:0] last_pos;
  logic             last_err, last_warn, last_ok;

  enc_rd_master #(
    .POS_W    (POS_W),
    .HALF_DIV (HALF_DIV),
    .ACK_LIMIT(ACK_LIMIT)
  ) i_enc_rd_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .sdi_i    (sdi),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .timeout_o(timeout_o),
    .pos_o    (pos_o),
    .err_o    (err_o),
    .warn_o   (warn_o),
    .crc_ok_o (crc_ok_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge sclk_o) sclk_rises++;

  task automatic chk(bit cond, string rq, string what, longint act, longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Independent model of the check sequence: start at 0, x^6+x+1, MSB first.
  function automatic logic [5:0] model_crc(logic [63:0] bits, int n);
    logic [5:0] r;
    r = 6'd0;
    for (int i = n - 1; i >= 0; i--) begin
      logic t;
      t = r[5] ^ bits[i];
      r = {r[4:0], 1'b0};
      if (t) r = r ^ 6'b000011;
    end
    return r;
  endfunction

  // Behavioural encoder: reacts to the serial clock rising edges.
  task automatic enc_serve(int ack, logic [63:0] bits, int len);
    @(posedge sclk_o);
    @(posedge sclk_o);
    sdi = 1'b0;
    repeat (ack - 1) @(posedge sclk_o);
    for (int i = len - 1; i >= 0; i--) begin
      @(posedge sclk_o);
      sdi = bits[i];
    end
    @(posedge sclk_o);
    sdi = 1'b0;
    repeat (20) @(posedge clk);
    sdi = 1'b1;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic measure_clock();
    time t0, t1, t2, t3;
    @(posedge req);
    t0 = $time + CLK_PERIOD/2;
    @(negedge sclk_o);
    t1 = $time;
    @(posedge sclk_o);
    t2 = $time;
    @(negedge sclk_o);
    t3 = $time;
    chk((t1 - t0) == HALF_DIV*CLK_PERIOD, "R3", "first fall delay", longint'(t1 - t0), longint'(HALF_DIV*CLK_PERIOD));
    chk((t2 - t1) == HALF_DIV*CLK_PERIOD, "R3", "low half period", longint'(t2 - t1), longint'(HALF_DIV*CLK_PERIOD));
    chk((t3 - t2) == HALF_DIV*CLK_PERIOD, "R3", "high half period", longint'(t3 - t2), longint'(HALF_DIV*CLK_PERIOD));
  endtask

  // Driver: pushes the expected result, then runs one read.
  task automatic do_read(logic [POS_W-1:0] pos, logic errb, logic warnb, int ack,
                         logic zero_bit, logic [5:0] crc_flip, bit extra_req);
    logic [POS_W+1:0] data;
    logic [5:0]       c;
    logic [63:0]      frame;
    int               len;
    int               r0;
    exp_t             e;
    data  = {pos, errb, warnb};
    c     = model_crc(64'(data), POS_W + 2);
    frame = 64'({1'b1, zero_bit, data, (~c) ^ crc_flip});
    len   = POS_W + 10;
    e.tmo  = 1'b0;
    e.pos  = pos;
    e.err  = ~errb;
    e.warn = ~warnb;
    e.ok   = (crc_flip == 6'd0) && (zero_bit == 1'b0);
    exp_q.push_back(e);
    last_pos = e.pos; last_err = e.err; last_warn = e.warn; last_ok = e.ok;
    repeat (5) @(posedge clk);
    pulse_req();
    if (extra_req) begin
      fork
        begin
          repeat (40) @(negedge clk);
          req = 1'b1;
          @(negedge clk);
          req = 1'b0;
        end
      join_none
    end
    enc_serve(ack, frame, len);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chk(sclk_o == 1'b1, "R9", "clock high after read", longint'(sclk_o), 1);
    r0 = sclk_rises;
    repeat (30) @(negedge clk);
    chk(sclk_rises == r0, "R9", "no rising edges after last bit", longint'(sclk_rises - r0), 0);
    chk(pos_o == pos, "R9", "position held", longint'(pos_o), longint'(pos));
  endtask

  task automatic do_stall();
    exp_t e;
    int   r0;
    e.tmo  = 1'b1;
    e.pos  = last_pos;
    e.err  = last_err;
    e.warn = last_warn;
    e.ok   = last_ok;
    exp_q.push_back(e);
    repeat (5) @(posedge clk);
    r0 = sclk_rises;
    pulse_req();
    @(posedge sclk_o);
    @(posedge sclk_o);
    sdi = 1'b0;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chk((sclk_rises - r0) == 2 + ACK_LIMIT, "R8", "rising edges before abort",
        longint'(sclk_rises - r0), longint'(2 + ACK_LIMIT));
    chk(sclk_o == 1'b1, "R8", "clock high after abort", longint'(sclk_o), 1);
    repeat (10) @(posedge clk);
    sdi = 1'b1;
  endtask

  // Monitor: pops the scoreboard on each completion or new timeout.
  initial begin
    to_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (done_o || (timeout_o && !to_prev)) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected result", longint'(done_o), 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(timeout_o == e.tmo, "R8", "timeout flag", longint'(timeout_o), longint'(e.tmo));
            chk(done_o == !e.tmo, "R9", "done pulse", longint'(done_o), longint'(!e.tmo));
            chk(pos_o == e.pos, "R5", "position", longint'(pos_o), longint'(e.pos));
            chk(err_o == e.err, "R6", "error flag", longint'(err_o), longint'(e.err));
            chk(warn_o == e.warn, "R6", "warning flag", longint'(warn_o), longint'(e.warn));
            chk(crc_ok_o == e.ok, "R7", "crc valid", longint'(crc_ok_o), longint'(e.ok));
          end
        end
        to_prev = timeout_o;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok_idle;
    checks = 0; fails = 0; sclk_rises = 0; finished = 1'b0;
    req = 1'b0; sdi = 1'b1; rst_n = 1'b0;
    last_pos = '0; last_err = 1'b0; last_warn = 1'b0; last_ok = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclk_o == 1'b1, "R1", "reset sclk", longint'(sclk_o), 1);
    chk(busy_o == 1'b0, "R1", "reset busy", longint'(busy_o), 0);
    chk(done_o == 1'b0 && timeout_o == 1'b0, "R1", "reset done/timeout", longint'({done_o, timeout_o}), 0);
    chk(pos_o == '0 && crc_ok_o == 1'b0 && err_o == 1'b0 && warn_o == 1'b0, "R1", "reset outputs",
        longint'(pos_o), 0);

    // R3, R4, R5, R6, R7: healthy frame with clock timing measured
    fork
      measure_clock();
    join_none
    do_read(26'h2A5C3F1, 1'b1, 1'b1, 3, 1'b0, 6'd0, 1'b0);
    // R4 shortest acknowledge, R6 error bit active
    do_read({POS_W{1'b1}}, 1'b0, 1'b1, 1, 1'b0, 6'd0, 1'b0);
    // R6 warning bit active, longer acknowledge
    do_read(26'h0000001, 1'b1, 1'b0, 10, 1'b0, 6'd0, 1'b0);
    // R7 corrupted check bits
    do_read(26'h1234567, 1'b1, 1'b1, 2, 1'b0, 6'b000100, 1'b0);
    // R7 zero bit sent as 1
    do_read(26'h0ABCDEF, 1'b1, 1'b1, 2, 1'b1, 6'd0, 1'b0);
    // R4 longest acknowledge that still succeeds
    do_read(26'h3C0FFEE, 1'b0, 1'b0, ACK_LIMIT - 1, 1'b0, 6'd0, 1'b0);
    // R8 encoder never sends a start bit
    do_stall();
    chk(timeout_o == 1'b1, "R8", "timeout held while idle", longint'(timeout_o), 1);

    // R2 request while the encoder is not ready is ignored
    sdi = 1'b0;
    repeat (5) @(posedge clk);
    pulse_req();
    ok_idle = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy_o || !sclk_o) ok_idle = 1'b0;
    end
    chk(ok_idle, "R2", "not-ready request ignored", longint'(ok_idle), 1);
    sdi = 1'b1;

    // R2 extra request during a read is ignored; R8 timeout cleared
    do_read(26'h155AAAA, 1'b1, 1'b1, 4, 1'b0, 6'd0, 1'b1);
    chk(timeout_o == 1'b0, "R8", "timeout cleared by new read", longint'(timeout_o), 0);
    repeat (50) @(negedge clk);
    chk(busy_o == 1'b0, "R2", "no second read started", longint'(busy_o), 0);
    chk(exp_q.size() == 0, "R9", "all results delivered", longint'(exp_q.size()), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule